// File: doc/BRIEF.md
# Serial Command Decoder with Dot RAM

This block sits between a three-wire serial host link (data, shift clock, load strobe) and the scanner of a small dot-matrix character display. The host drops the load strobe, shifts in one byte least-significant bit first, and raises the strobe again. The rising strobe commits the byte. Its upper three bits select a command class and its lower five bits carry the operand.

A committed byte can do one of four things. It can point the block at one of ten characters. It can write one five-dot row of the character chosen by an earlier address byte. It can store a five-bit display control word, which covers the brightness, lamp-test and power-down codes. It can wipe the dot storage through a software clear. The storage holds 10 characters × 5 rows × 5 columns. A separate combinational read port lets the scanner fetch any row at any time.

The serial pins are asynchronous to the system clock. They are brought in through a synchroniser, and their edges are found in the system clock domain. The active-low reset asserts asynchronously.

Top module: `dotcmd_top`

## Requirements
- R1: While `ser_load` is low, each rising edge of `ser_clk` shifts `ser_data` into an 8-bit register, and the first bit received becomes bit 0. Edges of `ser_clk` while `ser_load` is high have no effect.
- R2: A rising `ser_load` commits the byte only if exactly eight shift edges occurred since the previous rising `ser_load`. Otherwise the byte is dropped and no output changes.
- R3: Bits 7..5 = 3'b101 with bits 4..0 in 5'b10000..5'b11001 set `char_addr` to bits 3..0, which gives characters 0..9.
- R4: Bits 7..5 = 0..4 write bits 4..0 into row 0..4 of the character in `char_addr`. Read back through `rd_cols`, bit 4 is column 0 and bit 0 is column 4.
- R5: Bits 7..5 = 3'b111 load bits 4..0 into `ctrl_word`. Examples are 5'b10000..5'b10110 for brightness, 5'b11000 for lamp test and 5'b11111 for power-down.
- R6: Byte 8'hC0 zeroes all dots and sets `char_addr` to 0, and leaves `ctrl_word` unchanged. It also raises `clr_hold`, which stays high until `ser_load` next falls.
- R7: Reset gives all dots 0, `char_addr` 0, `ctrl_word` 5'b10000 and `clr_hold` 0.
- R8: An address byte with a payload outside 5'b10000..5'b11001, or an opcode of 3'b110 with a non-zero payload, changes no state.
- R9: Row writes are accepted while `ctrl_word` holds the power-down code 5'b11111.
- R10: `rd_cols` shows the row picked by `rd_char`/`rd_row` in the same cycle. It reads 0 when `rd_char` > 9 or `rd_row` > 4.
- R11: Register and dot updates become visible exactly four `clk` rising edges after the first edge that samples `ser_load` high. After three edges the old values remain.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset, asynchronous assertion |
| ser_data | input | 1 | Serial data bit |
| ser_clk | input | 1 | Serial shift clock, sampled on its rising edge |
| ser_load | input | 1 | Load strobe: low to shift, rising edge commits |
| rd_char | input | 4 | Scanner character index |
| rd_row | input | 3 | Scanner row index |
| rd_cols | output | 5 | Dots of the selected row, bit 4 = column 0 |
| char_addr | output | 4 | Current character address |
| ctrl_word | output | 5 | Current control word |
| clr_hold | output | 1 | High from a software clear until the next byte begins |

## Verification
A committed byte passes through two synchroniser stages, one edge-detect and commit stage, and one update stage. Address, control word and dot contents therefore change on the fourth system clock edge after `ser_load` is first sampled high. The bench waits eight cycles after each byte before it samples, and one directed case samples after edge three and again after edge four to pin the latency exactly. The scanner read port is combinational, so its results are read one time step after `rd_char`/`rd_row` change, with no clock in between. `clr_hold` release is checked a few cycles after the strobe falls.

// File: rtl/dotcmd_pkg.sv
// Shared constants and opcode encoding for the serial dot command decoder.
package dotcmd_pkg;
    localparam int NCHAR  = 10;                  // characters held
    localparam int NROW   = 5;                   // rows per character
    localparam int NCOL   = 5;                   // dots per row
    localparam int BYTE_W = 8;                   // serial frame length
    localparam int OP_W   = 3;                   // opcode field width
    localparam int PAY_W  = BYTE_W - OP_W;       // operand width
    localparam int CA_W   = $clog2(NCHAR);       // character address width
    localparam int RA_W   = $clog2(NROW);        // row index width
    localparam int CNT_W  = $clog2(BYTE_W + 2);  // shift counter width

    localparam logic [PAY_W-1:0] CTRL_RST = 5'b10000;  // full brightness, no lamp test

    typedef enum logic [OP_W-1:0] {
        OP_ROW0  = 3'd0,
        OP_ROW1  = 3'd1,
        OP_ROW2  = 3'd2,
        OP_ROW3  = 3'd3,
        OP_ROW4  = 3'd4,
        OP_ADDR  = 3'd5,
        OP_CLEAR = 3'd6,
        OP_CTRL  = 3'd7
    } op_e;
endpackage

// File: rtl/dotcmd_sync.sv
// Multi-stage level synchroniser for a bundle of asynchronous inputs.
// Assumes each input is stable for several clk periods between changes,
// so that the bits stay aligned after synchronisation. STAGES >= 2.
module dotcmd_sync #(
    parameter int WIDTH  = 3,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_in,
    output logic [WIDTH-1:0] sync_out
);
    logic [STAGES-1:0][WIDTH-1:0] stg;

    // Shift the raw inputs through the synchroniser chain.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stg <= '0;
        else        stg <= {stg[STAGES-2:0], async_in};
    end

    assign sync_out = stg[STAGES-1];
endmodule

// File: rtl/dotcmd_shifter.sv
// Serial byte receiver. It works on synchronised levels, finds the edges
// of the shift clock and load strobe, and shifts LSB first while the
// strobe is low. On the strobe's rising edge it emits a one-cycle commit,
// but only when exactly BYTE_W shift edges were seen (R1, R2).
module dotcmd_shifter
    import dotcmd_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sdata,
    input  logic              sclk,
    input  logic              sload,
    output logic              cmd_valid,
    output logic [BYTE_W-1:0] cmd_byte,
    output logic              frame_start
);
    localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(BYTE_W);
    localparam logic [CNT_W-1:0] CNT_SAT  = CNT_W'(BYTE_W + 1);

    logic              sclk_q, sload_q;
    logic              sclk_rise, load_rise;
    logic [BYTE_W-1:0] shreg;
    logic [CNT_W-1:0]  cnt;

    assign sclk_rise   = sclk & ~sclk_q;
    assign load_rise   = sload & ~sload_q;
    assign frame_start = ~sload & sload_q;

    // Remember the previous levels for edge detection.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sclk_q  <= 1'b0;
            sload_q <= 1'b0;
        end else begin
            sclk_q  <= sclk;
            sload_q <= sload;
        end
    end

    // Shift data in while the strobe is low; count edges, saturating past a byte.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            shreg <= '0;
            cnt   <= '0;
        end else if (load_rise) begin
            cnt <= '0;
        end else if (!sload && sclk_rise) begin
            shreg <= {sdata, shreg[BYTE_W-1:1]};
            cnt   <= (cnt == CNT_SAT) ? cnt : cnt + 1'b1;
        end
    end

    // Commit the byte on the strobe's rising edge when the count is exact.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cmd_valid <= 1'b0;
            cmd_byte  <= '0;
        end else begin
            cmd_valid <= load_rise && (cnt == CNT_FULL);
            if (load_rise) cmd_byte <= shreg;
        end
    end
endmodule

// File: rtl/dotcmd_decode.sv
// Opcode decoder and register file. It holds the character address, the
// control word and the clear-hold flag, and produces row-write and clear
// strobes for the dot storage. Assumes cmd_valid is a single-cycle pulse.
module dotcmd_decode
    import dotcmd_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_valid,
    input  logic [BYTE_W-1:0] cmd_byte,
    input  logic              frame_start,
    output logic [CA_W-1:0]   char_addr,
    output logic [PAY_W-1:0]  ctrl_word,
    output logic              clr_hold,
    output logic              wr_en,
    output logic [RA_W-1:0]   wr_row,
    output logic [NCOL-1:0]   wr_data,
    output logic              clr_pulse
);
    op_e              op;
    logic [PAY_W-1:0] pay;
    logic             addr_ok;
    logic             addr_ld;
    logic             ctrl_ld;

    assign op  = op_e'(cmd_byte[BYTE_W-1 -: OP_W]);
    assign pay = cmd_byte[PAY_W-1:0];

    // Classify the committed byte (R3, R4, R5, R6, R8).
    always_comb begin
        addr_ok   = pay[PAY_W-1] && (int'(pay[CA_W-1:0]) < NCHAR);
        addr_ld   = cmd_valid && (op == OP_ADDR) && addr_ok;
        ctrl_ld   = cmd_valid && (op == OP_CTRL);
        clr_pulse = cmd_valid && (op == OP_CLEAR) && (pay == '0);
        wr_en     = cmd_valid && (int'(op) < NROW);
        wr_row    = cmd_byte[PAY_W +: RA_W];
        wr_data   = pay;
    end

    // Character address: load on a valid address byte, zero on clear.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)         char_addr <= '0;
        else if (clr_pulse) char_addr <= '0;
        else if (addr_ld)   char_addr <= pay[CA_W-1:0];
    end

    // Control word: loaded only by the control opcode, kept on clear.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       ctrl_word <= CTRL_RST;
        else if (ctrl_ld) ctrl_word <= pay;
    end

    // Clear-hold flag: set by a clear, dropped when the next frame starts.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)           clr_hold <= 1'b0;
        else if (clr_pulse)   clr_hold <= 1'b1;
        else if (frame_start) clr_hold <= 1'b0;
    end
endmodule

// File: rtl/dotcmd_ram.sv
// Dot storage, NCHAR x NROW rows of NCOL bits, built from flops. It has one
// synchronous write port, a whole-array clear, and a combinational read
// port for the scanner that returns zero for out-of-range indices (R10).
module dotcmd_ram
    import dotcmd_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic            clr,
    input  logic            wr_en,
    input  logic [CA_W-1:0] wr_char,
    input  logic [RA_W-1:0] wr_row,
    input  logic [NCOL-1:0] wr_data,
    input  logic [CA_W-1:0] rd_char,
    input  logic [RA_W-1:0] rd_row,
    output logic [NCOL-1:0] rd_data
);
    logic [NCOL-1:0] mem [NCHAR][NROW];
    logic [NCHAR-1:0] char_hit;

    // Per-character write select.
    for (genvar c = 0; c < NCHAR; c++) begin : g_hit
        assign char_hit[c] = wr_en && (wr_char == CA_W'(c));
    end

    // Write or clear the addressed row; everything is zero after reset.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int c = 0; c < NCHAR; c++)
                for (int r = 0; r < NROW; r++)
                    mem[c][r] <= '0;
        end else begin
            for (int c = 0; c < NCHAR; c++)
                for (int r = 0; r < NROW; r++)
                    if (clr)
                        mem[c][r] <= '0;
                    else if (char_hit[c] && (wr_row == RA_W'(r)))
                        mem[c][r] <= wr_data;
        end
    end

    // Scanner read, guarded against indices beyond the array.
    always_comb begin
        rd_data = '0;
        if ((int'(rd_char) < NCHAR) && (int'(rd_row) < NROW))
            rd_data = mem[rd_char][rd_row];
    end
endmodule

// File: rtl/dotcmd_top.sv
// Serial command decoder with dot storage. It synchronises the serial
// pins, assembles bytes, decodes them into register and row updates, and
// exposes the dots to a scanner. Assumes each serial level is held for at
// least SYNC_STAGES+1 clk periods.
module dotcmd_top
    import dotcmd_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            ser_data,
    input  logic            ser_clk,
    input  logic            ser_load,
    input  logic [CA_W-1:0] rd_char,
    input  logic [RA_W-1:0] rd_row,
    output logic [NCOL-1:0] rd_cols,
    output logic [CA_W-1:0] char_addr,
    output logic [PAY_W-1:0] ctrl_word,
    output logic            clr_hold
);
    logic [2:0]        pins_s;
    logic              cmd_valid;
    logic [BYTE_W-1:0] cmd_byte;
    logic              frame_start;
    logic              wr_en;
    logic [RA_W-1:0]   wr_row;
    logic [NCOL-1:0]   wr_data;
    logic              clr_pulse;

    dotcmd_sync #(.WIDTH(3), .STAGES(SYNC_STAGES)) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .async_in ({ser_load, ser_clk, ser_data}),
        .sync_out (pins_s)
    );

    dotcmd_shifter u_shift (
        .clk         (clk),
        .rst_n       (rst_n),
        .sdata       (pins_s[0]),
        .sclk        (pins_s[1]),
        .sload       (pins_s[2]),
        .cmd_valid   (cmd_valid),
        .cmd_byte    (cmd_byte),
        .frame_start (frame_start)
    );

    dotcmd_decode u_dec (
        .clk         (clk),
        .rst_n       (rst_n),
        .cmd_valid   (cmd_valid),
        .cmd_byte    (cmd_byte),
        .frame_start (frame_start),
        .char_addr   (char_addr),
        .ctrl_word   (ctrl_word),
        .clr_hold    (clr_hold),
        .wr_en       (wr_en),
        .wr_row      (wr_row),
        .wr_data     (wr_data),
        .clr_pulse   (clr_pulse)
    );

    dotcmd_ram u_ram (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr     (clr_pulse),
        .wr_en   (wr_en),
        .wr_char (char_addr),
        .wr_row  (wr_row),
        .wr_data (wr_data),
        .rd_char (rd_char),
        .rd_row  (rd_row),
        .rd_data (rd_cols)
    );
endmodule

// File: rtl/dotcmd_chk.sv
// Property checker for dotcmd_top, bound to the internal commit stream.
module dotcmd_chk
    import dotcmd_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              cmd_valid,
    input logic [BYTE_W-1:0] cmd_byte,
    input logic [CA_W-1:0]   char_addr,
    input logic [PAY_W-1:0]  ctrl_word,
    input logic              clr_hold
);
    logic addr_byte, addr_in_range;
    assign addr_byte     = cmd_valid && (cmd_byte[BYTE_W-1 -: OP_W] == 3'b101);
    assign addr_in_range = cmd_byte[4] && (int'(cmd_byte[3:0]) < NCHAR);

    p_addr_range_r3: assert property (@(posedge clk) disable iff (!rst_n)
        int'(char_addr) < NCHAR);

    p_addr_load_r3: assert property (@(posedge clk) disable iff (!rst_n)
        addr_byte && addr_in_range |=> char_addr == $past(cmd_byte[CA_W-1:0]));

    p_bad_addr_r8: assert property (@(posedge clk) disable iff (!rst_n)
        addr_byte && !addr_in_range |=> $stable(char_addr));

    p_ctrl_load_r5: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid && (cmd_byte[BYTE_W-1 -: OP_W] == 3'b111)
        |=> ctrl_word == $past(cmd_byte[PAY_W-1:0]));

    p_ctrl_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !cmd_valid |=> $stable(ctrl_word));

    p_soft_clear_r6: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid && (cmd_byte == 8'hC0)
        |=> (char_addr == '0) && clr_hold && $stable(ctrl_word));
endmodule

bind dotcmd_top dotcmd_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .cmd_valid (cmd_valid),
    .cmd_byte  (cmd_byte),
    .char_addr (char_addr),
    .ctrl_word (ctrl_word),
    .clr_hold  (clr_hold)
);

// File: tb/sim_dotcmd_top.sv
module sim_dotcmd_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       ser_data = 1'b0;
    logic       ser_clk = 1'b0;
    logic       ser_load = 1'b1;
    logic [3:0] rd_char = '0;
    logic [2:0] rd_row = '0;
    logic [4:0] rd_cols;
    logic [3:0] char_addr;
    logic [4:0] ctrl_word;
    logic       clr_hold;

    int n_run = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;  // 50 MHz

    dotcmd_top u0 (
        .clk(clk), .rst_n(rst_n), .ser_data(ser_data), .ser_clk(ser_clk),
        .ser_load(ser_load), .rd_char(rd_char), .rd_row(rd_row),
        .rd_cols(rd_cols), .char_addr(char_addr), .ctrl_word(ctrl_word),
        .clr_hold(clr_hold)
    );

    // {byte, read char, read row, expected cols, expected addr, expected ctrl}
    localparam int NVEC = 11;
    localparam logic [28:0] VEC [NVEC] = '{
        {8'hB3, 4'd3, 3'd0, 5'b00000, 4'd3, 5'b10000},  // select char 3
        {8'h1E, 4'd3, 3'd0, 5'b11110, 4'd3, 5'b10000},  // row 0
        {8'h31, 4'd3, 3'd1, 5'b10001, 4'd3, 5'b10000},  // row 1
        {8'hF5, 4'd3, 3'd0, 5'b11110, 4'd3, 5'b10101},  // brightness
        {8'hB9, 4'd9, 3'd4, 5'b00000, 4'd9, 5'b10101},  // select char 9
        {8'h9F, 4'd9, 3'd4, 5'b11111, 4'd9, 5'b10101},  // row 4
        {8'hBA, 4'd9, 3'd4, 5'b11111, 4'd9, 5'b10101},  // bad address, ignored
        {8'hFF, 4'd9, 3'd4, 5'b11111, 4'd9, 5'b11111},  // power-down
        {8'h4A, 4'd9, 3'd2, 5'b01010, 4'd9, 5'b11111},  // write in power-down
        {8'hC5, 4'd3, 3'd0, 5'b11110, 4'd9, 5'b11111},  // undefined, ignored
        {8'hF8, 4'd3, 3'd1, 5'b10001, 4'd9, 5'b11000}   // lamp test
    };

    task automatic tick(input int n);
        repeat (n) @(posedge clk);
        #2;
    endtask

    task automatic chk(input string what, input int act, input int exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", what, act, exp);
        end
    endtask

    task automatic shift_bits(input logic [7:0] b, input int n);
        ser_load = 1'b0;
        tick(3);
        for (int i = 0; i < n; i++) begin
            ser_clk  = 1'b0;
            ser_data = (i < 8) ? b[i] : 1'b0;
            tick(3);
            ser_clk = 1'b1;
            tick(3);
        end
    endtask

    task automatic send(input logic [7:0] b, input int n);
        shift_bits(b, n);
        ser_load = 1'b1;
        tick(8);
    endtask

    task automatic rd(input int c, input int r);
        rd_char = 4'(c);
        rd_row  = 3'(r);
        #1;
    endtask

    task automatic summary;
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    endtask

    initial begin
        tick(5);
        rst_n = 1'b1;
        tick(4);

        // R7: state after reset
        chk("R7 addr", char_addr, 0);
        chk("R7 ctrl", ctrl_word, 5'b10000);
        chk("R7 clr_hold", clr_hold, 0);
        rd(0, 0); chk("R7 dots c0r0", rd_cols, 0);
        rd(9, 4); chk("R7 dots c9r4", rd_cols, 0);

        // Vector table: R1 R3 R4 R5 R8 R9
        for (int k = 0; k < NVEC; k++) begin
            send(VEC[k][28:21], 8);
            rd(VEC[k][20:17], VEC[k][16:14]);
            chk($sformatf("R1 R4 cols v%0d", k), rd_cols, VEC[k][13:9]);
            chk($sformatf("R3 R8 addr v%0d", k), char_addr, VEC[k][8:5]);
            chk($sformatf("R5 R9 ctrl v%0d", k), ctrl_word, VEC[k][4:0]);
        end

        // R2: short and long frames are dropped, exact frame commits
        send(8'hB1, 7);
        chk("R2 seven bits dropped", char_addr, 9);
        send(8'hB1, 9);
        chk("R2 nine bits dropped", char_addr, 9);
        send(8'hB1, 8);
        chk("R2 eight bits commit", char_addr, 1);

        // R1: serial clock edges with load high do nothing
        ser_data = 1'b1;
        for (int i = 0; i < 4; i++) begin
            ser_clk = 1'b0; tick(3);
            ser_clk = 1'b1; tick(3);
        end
        tick(6);
        chk("R1 idle edges addr", char_addr, 1);
        chk("R1 idle edges ctrl", ctrl_word, 5'b11000);
        send(8'hF3, 8);
        chk("R1 next byte clean", ctrl_word, 5'b10011);

        // R8: undefined clear variant leaves state alone
        send(8'hC7, 8);
        rd(3, 0); chk("R8 undefined dots", rd_cols, 5'b11110);
        chk("R8 undefined addr", char_addr, 1);
        chk("R8 undefined ctrl", ctrl_word, 5'b10011);

        // R6: software clear
        send(8'hC0, 8);
        rd(3, 0); chk("R6 dots c3r0", rd_cols, 0);
        rd(9, 2); chk("R6 dots c9r2", rd_cols, 0);
        chk("R6 addr", char_addr, 0);
        chk("R6 ctrl kept", ctrl_word, 5'b10011);
        chk("R6 clr_hold set", clr_hold, 1);
        ser_load = 1'b0;
        tick(5);
        chk("R6 clr_hold released", clr_hold, 0);
        ser_load = 1'b1;
        tick(8);

        // R10: read port, combinational and range-guarded
        send(8'hB0, 8);
        send(8'h8A, 8);
        rd(0, 4); chk("R10 read c0r4", rd_cols, 5'b01010);
        rd(0, 3); chk("R10 same-cycle change", rd_cols, 0);
        rd(10, 4); chk("R10 char out of range", rd_cols, 0);
        rd(0, 5); chk("R10 row out of range", rd_cols, 0);

        // R11: update latency of exactly four edges
        shift_bits(8'hF4, 8);
        tick(1);
        ser_load = 1'b1;
        tick(3);
        chk("R11 old after three edges", ctrl_word, 5'b10011);
        tick(1);
        chk("R11 new after four edges", ctrl_word, 5'b10100);
        tick(6);

        // R7: reset in mid-run
        rst_n = 1'b0;
        tick(2);
        chk("R7 rerun ctrl", ctrl_word, 5'b10000);
        chk("R7 rerun addr", char_addr, 0);
        rd(0, 4); chk("R7 rerun dots", rd_cols, 0);
        rst_n = 1'b1;
        tick(4);

        done = 1'b1;
        summary();
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_run++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            summary();
            $finish;
        end
    end
endmodule